// File: doc/BRIEF.md
# UART Receive Command Controller

This block holds the command logic on the receive side of a UART. Software controls it through one 32-bit command register that cannot be read back. Each write carries up to six one-shot command bits. Those bits update two persistent settings:

- whether the receiver accepts characters;
- whether the receive FIFO write path is locked.

A write can also raise two flush pulses. One restarts the receive state machine that lives outside this block. The other empties the receive FIFO.

Characters arrive from an external deserializer on a valid/data strobe. The block keeps them in a small show-ahead FIFO. When the write path is locked, a character the receiver has accepted is not stored. It still raises the per-character event pulse, and the block counts it as dropped. Baud generation, framing and address matching sit outside the block.

Top module: `uart_rx_cmd_ctrl`

## Requirements
- R1: Command bits sit at fixed positions in the written word: bit 7 enables reception, bit 6 disables it, bit 5 flushes the receive machine, bit 4 flushes the FIFO, bit 3 locks the FIFO write path and bit 2 unlocks it. A write with bit 7 set makes `rx_enabled` high from the next clock edge.
- R2: `cmd_rdata` reads as zero at all times, whatever has been written.
- R3: A write with bit 6 set makes `rx_enabled` low from the next edge. When bits 6 and 7 are both set, disable wins.
- R4: A write with bit 5 set gives a one-cycle `rxsm_flush` pulse in the cycle after the write. The same write sets `rx_enabled`, clears `fifo_locked` and leaves the FIFO contents untouched. If bit 6 or bit 3 is set in the same write, that bit wins for its own setting.
- R5: A write with bit 4 set leaves the FIFO empty from the next edge and gives a one-cycle `fifo_flush` pulse in the cycle after the write. A character offered in the same cycle as the write is discarded.
- R6: While `rx_enabled` and `fifo_locked` are both high, an offered character is not stored. `char_event` still pulses for it, and `lock_drops` (saturating) increments by one.
- R7: A write with bit 2 set clears `fifo_locked`, and later characters are stored again. When bits 3 and 2 are both set, lock wins.
- R8: Bits written as 0 have no effect. Reserved bits 31:8 and 1:0 have no effect. The enable and lock settings persist between writes.
- R9: After reset, `rx_enabled` is low, `fifo_locked` is low, the FIFO is empty, `lock_drops` is zero and both flush pulses are low.
- R10: While `rx_enabled` is low, offered characters are ignored: nothing is stored, nothing is counted and `char_event` stays low.
- R11: The FIFO returns characters in arrival order on `rd_data`, which shows the oldest entry. When a character is accepted with the FIFO holding DEPTH entries, it is dropped, `overrun` pulses for one cycle and `fifo_count` stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word written |
| cmd_rdata | output | 32 | Command register read value (always zero) |
| char_valid | input | 1 | Deserializer offers a character this cycle |
| char_data | input | DATA_W | Offered character |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | DATA_W | Oldest FIFO entry |
| fifo_count | output | $clog2(DEPTH)+1 | FIFO occupancy |
| fifo_empty | output | 1 | FIFO holds nothing |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| rx_enabled | output | 1 | Reception enabled |
| fifo_locked | output | 1 | FIFO write path locked |
| rxsm_flush | output | 1 | One-cycle restart pulse for the receive state machine |
| fifo_flush | output | 1 | One-cycle pulse marking a FIFO flush |
| char_event | output | 1 | One-cycle pulse per character accepted while enabled |
| overrun | output | 1 | One-cycle pulse when a character is lost to a full FIFO |
| lock_drops | output | CNT_W | Saturating count of characters dropped while locked |

## Verification
A wrong enable or lock setting is visible one edge after the write that caused it: `rx_enabled` or `fifo_locked` shows the wrong level. The next offered character then lands in the wrong place, so `fifo_count`, `lock_drops` or `char_event` also disagree in the following cycle. A flush that was wrongly ordered against a same-cycle character leaves `fifo_count` nonzero one cycle after the write. Broken FIFO pointers show up as an out-of-order value on `rd_data` at the first pop after the fault.

// File: rtl/rxcmd_pkg.sv
package rxcmd_pkg;

    localparam int CMD_LSB = 2;
    localparam int CMD_MSB = 7;

    typedef struct packed {
        logic en;
        logic dis;
        logic sm_flush;
        logic q_flush;
        logic lock;
        logic unlock;
    } rx_cmd_t;

    function automatic rx_cmd_t cmd_decode(input logic [31:0] word);
        return rx_cmd_t'(word[CMD_MSB:CMD_LSB]);
    endfunction

    // disable beats enable, and both beat the enable implied by a machine flush
    function automatic logic next_enable(input rx_cmd_t c, input logic cur);
        if (c.dis)
            return 1'b0;
        else if (c.en || c.sm_flush)
            return 1'b1;
        else
            return cur;
    endfunction

    // lock beats unlock and beats the unlock implied by a machine flush
    function automatic logic next_lock(input rx_cmd_t c, input logic cur);
        if (c.lock)
            return 1'b1;
        else if (c.unlock || c.sm_flush)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/rxcmd_decode.sv
module rxcmd_decode
    import rxcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic        rx_en,
    output logic        locked,
    output logic        sm_flush_p,
    output logic        q_flush_p,
    output logic        q_clear
);
    rx_cmd_t cmd;

    always_comb begin
        cmd     = cmd_decode(cmd_wdata);
        q_clear = cmd_wr && cmd.q_flush;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en      <= 1'b0;
            locked     <= 1'b0;
            sm_flush_p <= 1'b0;
            q_flush_p  <= 1'b0;
        end else begin
            sm_flush_p <= cmd_wr && cmd.sm_flush;
            q_flush_p  <= cmd_wr && cmd.q_flush;
            if (cmd_wr) begin
                rx_en  <= next_enable(cmd, rx_en);
                locked <= next_lock(cmd, locked);
            end
        end
    end
endmodule

// File: rtl/rxcmd_fifo.sv
module rxcmd_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH):0] count,
    output logic              empty,
    output logic              full,
    output logic              overrun
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_wr, do_rd;

    always_comb begin
        empty = (count == '0);
        full  = (count == (AW+1)'(DEPTH));
        do_wr = wr_req && !full;
        do_rd = rd_en && !empty;
        rd_data = mem[rp];
    end

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr && !clear)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp      <= '0;
            rp      <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= wr_req && full;
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxcmd_drop_counter.sv
module rxcmd_drop_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [CNT_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (hit && value != '1)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/uart_rx_cmd_ctrl.sv
module uart_rx_cmd_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_wr,
    input  logic [31:0]             cmd_wdata,
    output logic [31:0]             cmd_rdata,
    input  logic                    char_valid,
    input  logic [DATA_W-1:0]       char_data,
    input  logic                    rd_en,
    output logic [DATA_W-1:0]       rd_data,
    output logic [$clog2(DEPTH):0]  fifo_count,
    output logic                    fifo_empty,
    output logic                    fifo_full,
    output logic                    rx_enabled,
    output logic                    fifo_locked,
    output logic                    rxsm_flush,
    output logic                    fifo_flush,
    output logic                    char_event,
    output logic                    overrun,
    output logic [CNT_W-1:0]        lock_drops
);
    logic q_clear;
    logic accept;
    logic store_req;
    logic lock_hit;

    assign cmd_rdata = '0;

    rxcmd_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .rx_en      (rx_enabled),
        .locked     (fifo_locked),
        .sm_flush_p (rxsm_flush),
        .q_flush_p  (fifo_flush),
        .q_clear    (q_clear)
    );

    always_comb begin
        accept    = char_valid && rx_enabled;
        store_req = accept && !fifo_locked && !q_clear;
        lock_hit  = accept && fifo_locked;
    end

    always_ff @(posedge clk) begin
        if (rst) char_event <= 1'b0;
        else     char_event <= accept;
    end

    rxcmd_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clear   (q_clear),
        .wr_req  (store_req),
        .wr_data (char_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (fifo_count),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .overrun (overrun)
    );

    rxcmd_drop_counter #(.CNT_W(CNT_W)) u_drops (
        .clk   (clk),
        .rst   (rst),
        .hit   (lock_hit),
        .value (lock_drops)
    );
endmodule

// File: rtl/rxcmd_checker.sv
module rxcmd_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cmd_wr,
    input logic [31:0]            cmd_wdata,
    input logic [31:0]            cmd_rdata,
    input logic                   char_valid,
    input logic                   rx_enabled,
    input logic                   fifo_locked,
    input logic                   rxsm_flush,
    input logic [$clog2(DEPTH):0] fifo_count,
    input logic [CNT_W-1:0]       lock_drops
);
    p_rdata_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata == 32'd0);

    p_disable_wins_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_wdata[6] |=> !rx_enabled);

    p_enable_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_wdata[7] && !cmd_wdata[6] |=> rx_enabled);

    p_machine_flush_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_wdata[5] && !cmd_wdata[6] && !cmd_wdata[3]
        |=> rxsm_flush && rx_enabled && !fifo_locked);

    p_fifo_flush_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_wdata[4] |=> fifo_count == '0);

    p_lock_wins_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_wdata[3] |=> fifo_locked);

    p_locked_no_grow_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_locked |=> fifo_count <= $past(fifo_count));

    p_idle_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(rx_enabled) && $stable(fifo_locked));

    p_disabled_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_enabled |=> fifo_count <= $past(fifo_count) && $stable(lock_drops));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind uart_rx_cmd_ctrl rxcmd_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_wdata   (cmd_wdata),
    .cmd_rdata   (cmd_rdata),
    .char_valid  (char_valid),
    .rx_enabled  (rx_enabled),
    .fifo_locked (fifo_locked),
    .rxsm_flush  (rxsm_flush),
    .fifo_count  (fifo_count),
    .lock_drops  (lock_drops)
);

// File: tb/uart_rx_cmd_ctrl_bench.sv
module uart_rx_cmd_ctrl_bench;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = 8;
    localparam int CW     = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic char_valid = 1'b0;
    logic [DATA_W-1:0] char_data = '0;
    logic rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0] fifo_count;
    logic fifo_empty, fifo_full, rx_enabled, fifo_locked;
    logic rxsm_flush, fifo_flush, char_event, overrun;
    logic [CNT_W-1:0] lock_drops;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_rx_cmd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_uart_rx_cmd_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .char_valid(char_valid), .char_data(char_data), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .rx_enabled(rx_enabled), .fifo_locked(fifo_locked), .rxsm_flush(rxsm_flush),
        .fifo_flush(fifo_flush), .char_event(char_event), .overrun(overrun),
        .lock_drops(lock_drops)
    );

    // {command byte, expected enable, expected lock}, applied in sequence from reset
    localparam logic [9:0] VEC [10] = '{
        {8'h80, 1'b1, 1'b0},   // R1 enable
        {8'h08, 1'b1, 1'b1},   // R6 lock
        {8'h04, 1'b1, 1'b0},   // R7 unlock
        {8'hC0, 1'b0, 1'b0},   // R3 disable wins
        {8'h0C, 1'b0, 1'b1},   // R7 lock wins
        {8'h00, 1'b0, 1'b1},   // R8 zero write
        {8'h20, 1'b1, 1'b0},   // R4 machine flush enables and unlocks
        {8'h60, 1'b0, 1'b0},   // R4 disable beats flush
        {8'h28, 1'b1, 1'b1},   // R4 lock beats flush
        {8'h03, 1'b1, 1'b1}    // R8 reserved bits
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_wdata = '0;
    endtask

    task automatic send_char(input logic [DATA_W-1:0] d);
        @(negedge clk);
        char_valid = 1'b1;
        char_data = d;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [DATA_W-1:0] d);
        @(negedge clk);
        check(req, 32'(rd_data), 32'(d));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        for (int i = 0; i < 10; i++) begin
            write_cmd({24'hFFFF00 & 24'h0, VEC[i][9:2]});
            check($sformatf("R1/R3/R4/R7/R8 vec%0d enable", i), 32'(rx_enabled), 32'(VEC[i][1]));
            check($sformatf("R6/R7/R8 vec%0d lock", i), 32'(fifo_locked), 32'(VEC[i][0]));
            check("R2 rdata", cmd_rdata, 32'd0);
        end

        // R8 high reserved bits with every command bit clear
        write_cmd(32'hFFFF_FF03);
        check("R8 reserved high enable", 32'(rx_enabled), 32'd1);
        check("R8 reserved high lock", 32'(fifo_locked), 32'd1);

        // R9 reset state
        do_reset();
        check("R9 enable", 32'(rx_enabled), 32'd0);
        check("R9 lock", 32'(fifo_locked), 32'd0);
        check("R9 empty", 32'(fifo_empty), 32'd1);
        check("R9 drops", 32'(lock_drops), 32'd0);
        check("R9 flush pulses", {30'd0, rxsm_flush, fifo_flush}, 32'd0);

        // R10 disabled: ignored
        @(negedge clk);
        char_valid = 1'b1;
        char_data = 8'h5A;
        @(negedge clk);
        char_valid = 1'b0;
        check("R10 no event", 32'(char_event), 32'd0);
        check("R10 no store", 32'(fifo_count), 32'd0);
        check("R10 no count", 32'(lock_drops), 32'd0);

        // R1 / R11 normal store and order
        write_cmd(32'h80);
        @(negedge clk);
        char_valid = 1'b1;
        char_data = 8'h11;
        @(negedge clk);
        char_valid = 1'b0;
        check("R1 event", 32'(char_event), 32'd1);
        check("R1 stored", 32'(fifo_count), 32'd1);
        send_char(8'h22);
        pop_expect("R11 order first", 8'h11);
        pop_expect("R11 order second", 8'h22);
        check("R11 drained", 32'(fifo_empty), 32'd1);

        // R6 lock drops but event continues
        write_cmd(32'h08);
        @(negedge clk);
        char_valid = 1'b1;
        char_data = 8'h33;
        @(negedge clk);
        char_valid = 1'b0;
        check("R6 event while locked", 32'(char_event), 32'd1);
        check("R6 drop count", 32'(lock_drops), 32'd1);
        check("R6 not stored", 32'(fifo_count), 32'd0);

        // R7 unlock reopens
        write_cmd(32'h04);
        send_char(8'h44);
        check("R7 stored after unlock", 32'(fifo_count), 32'd1);

        // R4 machine flush: pulse, FIFO kept
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = 32'h20;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R4 pulse", 32'(rxsm_flush), 32'd1);
        check("R4 fifo kept", 32'(fifo_count), 32'd1);
        @(negedge clk);
        check("R4 pulse single", 32'(rxsm_flush), 32'd0);

        // R5 FIFO flush with same-cycle character
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = 32'h10;
        char_valid = 1'b1;
        char_data = 8'h55;
        @(negedge clk);
        cmd_wr = 1'b0;
        char_valid = 1'b0;
        check("R5 emptied", 32'(fifo_count), 32'd0);
        check("R5 pulse", 32'(fifo_flush), 32'd1);
        @(negedge clk);
        check("R5 pulse single", 32'(fifo_flush), 32'd0);

        // R11 fill and overrun
        for (int k = 0; k < DEPTH; k++) send_char(8'hA0 + 8'(k));
        check("R11 full", 32'(fifo_full), 32'd1);
        send_char(8'hEE);
        check("R11 overrun pulse", 32'(overrun), 32'd1);
        check("R11 count held", 32'(fifo_count), 32'(DEPTH));
        for (int k = 0; k < DEPTH; k++) pop_expect("R11 full order", 8'hA0 + 8'(k));
        check("R11 empty after drain", 32'(fifo_empty), 32'd1);
        check("R2 rdata end", cmd_rdata, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule